// File: doc/BRIEF.md
# Dual-Half Timer/Counter with Capture

This block is a 16-bit timer/counter built from two 8-bit halves that a 2-bit mode field rearranges. The halves can run as two separate prescaled timers, as one prescaled timer beside one counter of external events, as a single chained 16-bit prescaled timer, or as a single 16-bit event counter. Every counting path stops on a programmed match value: the half (or the chained pair) goes back to zero on the next step and raises a sticky request flag. The low half and the high half have separate flags.

Each half owns a capture register. In the split modes the low trigger copies the low half and the high trigger copies the high half. In the chained modes either trigger copies the full 16-bit count. All external inputs (event and both triggers) are sampled only on the clock-enable tick. This means a pulse has to last across at least one tick to be seen. A shared 8-bit prescaler divides the tick for the timer paths. Software programs the block through a small write port and clears the flags by writing ones.

Top module: `tmrcap16`

## Requirements
- R1: After reset the count, both capture registers and both flags are zero, the mode is 0 and the prescaler counter is cleared.
- R2: While run is high, the prescaler gives one count pulse on every (P+1)-th tick, where P is the value at write address 0. Any write to the mode register (address 3) restarts the prescaler from zero.
- R3: Mode 0 (mode bits [1:0] of address 3 = 0): count bits [7:0] and [15:8] are two independent timers, and both step on each prescaler pulse.
- R4: Mode 1: bits [7:0] step on prescaler pulses. Bits [15:8] step on each accepted rising edge of the event input while run is high.
- R5: Mode 2: the 16-bit count steps on prescaler pulses. The low half carries into the high half when it passes 0xFF.
- R6: Mode 3: the 16-bit count steps on each accepted rising edge of the event input while run is high.
- R7: A counting unit that holds its match value goes to zero on its next step and sets its flag in that same clock. In modes 0 and 1 the low half uses the match at address 1 and sets the low flag, and the high half uses the match at address 2 and sets the high flag. In modes 2 and 3 the compare is against {address 2, address 1} and only the high flag is set.
- R8: The event and capture inputs are sampled only on ticks. A rising edge counts only when the input is seen low on one tick and high on the next tick. A pulse that falls entirely between two ticks is ignored.
- R9: A capture stores the count value from before the edge. This holds even when a step lands on the same clock. In modes 0 and 1 the low trigger loads the low capture from bits [7:0] and the high trigger loads the high capture from bits [15:8]. In modes 2 and 3 either trigger loads both captures from all 16 bits.
- R10: A flag stays set until data bit 0 (low flag) or bit 1 (high flag) is written as 1 to address 4. If a set and a clear fall on the same clock, the set wins.
- R11: While run is low, neither the count nor the prescaler moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock-enable tick (instruction cycle) |
| run_i | input | 1 | Counting enable |
| evt_i | input | 1 | Synchronized external event input |
| capl_i | input | 1 | Low-half capture trigger |
| caph_i | input | 1 | High-half capture trigger |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 prescale, 1 match low, 2 match high, 3 mode, 4 flag clear |
| wr_data_i | input | 8 | Write data |
| cap_lo_o | output | 8 | Low capture register |
| cap_hi_o | output | 8 | High capture register |
| count_o | output | 16 | Live count, high half in bits [15:8] |
| flag_lo_o | output | 1 | Low-half match flag |
| flag_hi_o | output | 1 | High-half match flag |

## Verification
Two functions can land on the same clock: a capture and a counter step, and a flag set and a software flag clear. The bench raises a capture trigger on the exact clock where a prescaler pulse advances the count. It then checks that the stored value equals the count read just before that edge, and that the live count has moved on by one. For flags, it sets match value 0 so that every step sets the flag, and writes the clear in that same clock. The flag must then read 1 afterwards.

// File: rtl/tmrcap_pkg.sv
package tmrcap_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL8 = 2'd0,
    MODE_MIX   = 2'd1,
    MODE_T16   = 2'd2,
    MODE_E16   = 2'd3
  } tmode_e;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PSC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MLO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MHI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;

  // chained 16-bit modes
  function automatic logic is_wide(input tmode_e m);
    return (m == MODE_T16) || (m == MODE_E16);
  endfunction

  // set has priority over a software clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tmrcap_edge.sv
module tmrcap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sig_i,
  output logic rise_o
);

  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (tick_i) seen_q <= sig_i;
  end

  // accepted edge: low on previous tick, high on this tick
  assign rise_o = tick_i & sig_i & ~seen_q;

endmodule

// File: rtl/tmrcap_presc.sv
module tmrcap_presc #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             pulse_o
);

  logic [PSC_W-1:0] div_cnt_q;
  logic             at_end;

  assign at_end = (div_cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_cnt_q <= '0;
    else if (restart_i)        div_cnt_q <= '0;
    else if (tick_i && run_i)  div_cnt_q <= at_end ? '0 : div_cnt_q + 1'b1;
  end

  assign pulse_o = tick_i & run_i & at_end & ~restart_i;

endmodule

// File: rtl/tmrcap_half.sv
module tmrcap_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         wrap_i,
  input  logic         take_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o
);

  function automatic logic [W-1:0] advance(input logic [W-1:0] c, input logic to_zero);
    return to_zero ? '0 : c + 1'b1;
  endfunction

  logic [W-1:0] cnt_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      if (step_i) cnt_q <= advance(cnt_q, wrap_i);
      if (take_i) cap_q <= cnt_q;   // value before any same-clock step
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

endmodule

// File: rtl/tmrcap16.sv
module tmrcap16
  import tmrcap_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned PSC_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                run_i,
  input  logic                evt_i,
  input  logic                capl_i,
  input  logic                caph_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [HALF_W-1:0]   wr_data_i,
  output logic [HALF_W-1:0]   cap_lo_o,
  output logic [HALF_W-1:0]   cap_hi_o,
  output logic [2*HALF_W-1:0] count_o,
  output logic                flag_lo_o,
  output logic                flag_hi_o
);

  localparam int unsigned NUM_IN = 3;
  localparam int unsigned N_HALF = 2;

  // ---------------- configuration registers ----------------
  logic [PSC_W-1:0]  psc_q;
  logic [HALF_W-1:0] mlo_q, mhi_q;
  tmode_e            mode_q;
  logic              wr_mode, clr_lo, clr_hi;

  assign wr_mode = wr_en_i && (wr_addr_i == A_MODE);
  assign clr_lo  = wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[0];
  assign clr_hi  = wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
      mode_q <= MODE_DUAL8;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_PSC) psc_q  <= wr_data_i[PSC_W-1:0];
      if (wr_addr_i == A_MLO) mlo_q  <= wr_data_i;
      if (wr_addr_i == A_MHI) mhi_q  <= wr_data_i;
      if (wr_mode)            mode_q <= tmode_e'(wr_data_i[1:0]);
    end
  end

  // ---------------- input edge sampling ----------------
  logic [NUM_IN-1:0] in_vec, rise_vec;
  logic              evt_rise, capl_rise, caph_rise;

  assign in_vec = {caph_i, capl_i, evt_i};

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    tmrcap_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .sig_i  (in_vec[gi]),
      .rise_o (rise_vec[gi])
    );
  end

  assign evt_rise  = rise_vec[0];
  assign capl_rise = rise_vec[1];
  assign caph_rise = rise_vec[2];

  // ---------------- prescaler ----------------
  logic pre_pulse;

  tmrcap_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (run_i),
    .restart_i (wr_mode),
    .div_i     (psc_q),
    .pulse_o   (pre_pulse)
  );

  // ---------------- step / wrap steering ----------------
  logic              wide, evt_step, src_lo, src_hi8;
  logic [HALF_W-1:0] cnt_arr [N_HALF];
  logic [HALF_W-1:0] cap_arr [N_HALF];
  logic [N_HALF-1:0] step_arr, wrap_arr, take_arr;
  logic              lo_eq, hi_eq, full_eq, lo_full;
  logic              flag_lo_set, flag_hi_set;
  logic              cap_lo_take, cap_hi_take;

  assign wide     = is_wide(mode_q);
  assign evt_step = evt_rise & run_i;
  assign src_lo   = (mode_q == MODE_E16) ? evt_step : pre_pulse;
  assign src_hi8  = (mode_q == MODE_MIX) ? evt_step : pre_pulse;

  assign lo_eq   = (cnt_arr[0] == mlo_q);
  assign hi_eq   = (cnt_arr[1] == mhi_q);
  assign full_eq = lo_eq & hi_eq;
  assign lo_full = &cnt_arr[0];

  always_comb begin
    step_arr[0] = src_lo;
    if (wide) begin
      wrap_arr[0] = full_eq;
      step_arr[1] = src_lo & (full_eq | lo_full);
      wrap_arr[1] = full_eq;
    end else begin
      wrap_arr[0] = lo_eq;
      step_arr[1] = src_hi8;
      wrap_arr[1] = hi_eq;
    end
  end

  assign flag_lo_set = ~wide & step_arr[0] & wrap_arr[0];
  assign flag_hi_set = step_arr[1] & wrap_arr[1];

  // ---------------- capture steering ----------------
  assign cap_lo_take = wide ? (capl_rise | caph_rise) : capl_rise;
  assign cap_hi_take = wide ? (capl_rise | caph_rise) : caph_rise;
  assign take_arr    = {cap_hi_take, cap_lo_take};

  for (genvar gh = 0; gh < N_HALF; gh++) begin : g_half
    tmrcap_half #(.W(HALF_W)) u_half (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step_arr[gh]),
      .wrap_i (wrap_arr[gh]),
      .take_i (take_arr[gh]),
      .cnt_o  (cnt_arr[gh]),
      .cap_o  (cap_arr[gh])
    );
  end

  // ---------------- request flags ----------------
  logic flag_lo_q, flag_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_lo_q <= 1'b0;
      flag_hi_q <= 1'b0;
    end else begin
      flag_lo_q <= flag_next(flag_lo_q, flag_lo_set, clr_lo);
      flag_hi_q <= flag_next(flag_hi_q, flag_hi_set, clr_hi);
    end
  end

  assign count_o   = {cnt_arr[1], cnt_arr[0]};
  assign cap_lo_o  = cap_arr[0];
  assign cap_hi_o  = cap_arr[1];
  assign flag_lo_o = flag_lo_q;
  assign flag_hi_o = flag_hi_q;

endmodule

// File: rtl/tmrcap16_chk.sv
module tmrcap16_chk #(
  parameter int unsigned HALF_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                run_i,
  input logic                wr_en_i,
  input logic [2:0]          wr_addr_i,
  input logic [HALF_W-1:0]   wr_data_i,
  input logic [2*HALF_W-1:0] count_o,
  input logic [HALF_W-1:0]   cap_lo_o,
  input logic                flag_lo_o,
  input logic                flag_hi_o,
  input logic [1:0]          mode_q,
  input logic                pre_pulse,
  input logic                flag_lo_set,
  input logic                flag_hi_set,
  input logic                cap_lo_take
);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_o));

  p_presc_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd0 && !pre_pulse) |=> $stable(count_o[HALF_W-1:0]));

  p_tick_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd3 && !tick_i) |=> $stable(count_o));

  p_wrap_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_lo_set |=> (count_o[HALF_W-1:0] == '0) && flag_lo_o);

  p_wrap_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_hi_set |=> flag_hi_o);

  p_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_lo_take |=> (cap_lo_o == $past(count_o[HALF_W-1:0])));

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_lo_o && !(wr_en_i && wr_addr_i == 3'd4 && wr_data_i[0])) |=> flag_lo_o);

endmodule

bind tmrcap16 tmrcap16_chk #(.HALF_W(HALF_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .run_i       (run_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .count_o     (count_o),
  .cap_lo_o    (cap_lo_o),
  .flag_lo_o   (flag_lo_o),
  .flag_hi_o   (flag_hi_o),
  .mode_q      (mode_q),
  .pre_pulse   (pre_pulse),
  .flag_lo_set (flag_lo_set),
  .flag_hi_set (flag_hi_set),
  .cap_lo_take (cap_lo_take)
);

// File: tb/tmrcap16_tb_top.sv
`timescale 1ns/1ps
module tmrcap16_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1, run = 1'b0, evt = 1'b0, capl = 1'b0, caph = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  cap_lo, cap_hi;
  logic [15:0] count;
  logic        flag_lo, flag_hi;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tmrcap16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .evt_i(evt),
    .capl_i(capl), .caph_i(caph), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cap_lo_o(cap_lo), .cap_hi_o(cap_hi),
    .count_o(count), .flag_lo_o(flag_lo), .flag_hi_o(flag_hi)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  psc;
    logic [7:0]  mlo;
    logic [7:0]  mhi;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd0,   8'd9,    8'd4,    16'd23},
    '{2'd0, 8'd3,   8'd200,  8'd200,  16'd40},
    '{2'd1, 8'd1,   8'd5,    8'd3,    16'd20},
    '{2'd2, 8'd0,   8'h2C,   8'h01,   16'd400},
    '{2'd2, 8'd1,   8'hFF,   8'hFF,   16'd600},
    '{2'd3, 8'd0,   8'h10,   8'h00,   16'd41},
    '{2'd0, 8'd255, 8'd3,    8'd3,    16'd768},
    '{2'd2, 8'd0,   8'hFF,   8'h00,   16'd300}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; evt = 1'b0; capl = 1'b0; caph = 1'b0;
    wr_en = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // n clocks with run high; event toggles each clock when asked
  task automatic run_for(input int n, input bit toggle);
    @(negedge clk);
    run = 1'b1; evt = toggle;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (toggle) evt = ~evt;
    end
    run = 1'b0; evt = 1'b0;
  endtask

  // closed-form expectation from the requirements
  task automatic expect_vec(input vec_t v, output logic [15:0] c, output logic fl, output logic fh);
    int pulses, events, big, lo, hi;
    pulses = int'(v.n) / (int'(v.psc) + 1);
    events = (int'(v.n) + 1) / 2;
    big    = {16'd0, v.mhi, v.mlo};
    case (v.mode)
      2'd0: begin
        lo = pulses % (int'(v.mlo) + 1); hi = pulses % (int'(v.mhi) + 1);
        c = {hi[7:0], lo[7:0]}; fl = pulses > int'(v.mlo); fh = pulses > int'(v.mhi);
      end
      2'd1: begin
        lo = pulses % (int'(v.mlo) + 1); hi = events % (int'(v.mhi) + 1);
        c = {hi[7:0], lo[7:0]}; fl = pulses > int'(v.mlo); fh = events > int'(v.mhi);
      end
      2'd2: begin
        lo = pulses % (big + 1); c = lo[15:0]; fl = 1'b0; fh = pulses > big;
      end
      default: begin
        lo = events % (big + 1); c = lo[15:0]; fl = 1'b0; fh = events > big;
      end
    endcase
  endtask

  initial begin : watchdog
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin : main
    logic [15:0] ec, v;
    logic        efl, efh;

    // R1: reset state
    do_reset();
    @(negedge clk);
    check("R1 count", count, 16'h0);
    check("R1 caps", {cap_hi, cap_lo}, 16'h0);
    check("R1 flags", {14'd0, flag_hi, flag_lo}, 16'h0);

    // vector table: R2 prescale, R3..R6 modes, R7 match/flags
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(3'd0, VECS[k].psc);
      wr(3'd1, VECS[k].mlo);
      wr(3'd2, VECS[k].mhi);
      wr(3'd3, {6'd0, VECS[k].mode});
      run_for(int'(VECS[k].n), 1'b1);
      @(negedge clk);
      expect_vec(VECS[k], ec, efl, efh);
      case (VECS[k].mode)
        2'd0:    check($sformatf("R3 R2 vec%0d count", k), count, ec);
        2'd1:    check($sformatf("R4 vec%0d count", k), count, ec);
        2'd2:    check($sformatf("R5 vec%0d count", k), count, ec);
        default: check($sformatf("R6 vec%0d count", k), count, ec);
      endcase
      check($sformatf("R7 vec%0d flags", k), {14'd0, flag_hi, flag_lo}, {14'd0, efh, efl});
    end

    // R1: reset clears a dirty state
    do_reset();
    @(negedge clk);
    check("R1 count after dirty", count, 16'h0);
    check("R1 flags after dirty", {14'd0, flag_hi, flag_lo}, 16'h0);

    // R10: sticky flags and write-one-to-clear
    do_reset();
    wr(3'd1, 8'd2); wr(3'd2, 8'd2); wr(3'd3, 8'd0);
    run_for(3, 1'b0);
    repeat (5) @(negedge clk);
    check("R10 sticky flags", {14'd0, flag_hi, flag_lo}, 16'h3);
    check("R7 wrap to zero", count, 16'h0);
    wr(3'd4, 8'h01);
    check("R10 clear low only", {14'd0, flag_hi, flag_lo}, 16'h2);
    wr(3'd4, 8'h02);
    check("R10 clear high", {14'd0, flag_hi, flag_lo}, 16'h0);

    // R11: run low holds the count
    do_reset();
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'd0);
    run_for(5, 1'b0);
    repeat (10) @(negedge clk);
    check("R11 hold", count, 16'h0505);

    // R9: capture coincident with a step stores the pre-step value
    run = 1'b1;
    repeat (3) @(negedge clk);
    v = count; capl = 1'b1;
    @(negedge clk);
    run = 1'b0; capl = 1'b0;
    check("R9 low capture pre-step", {8'd0, cap_lo}, {8'd0, v[7:0]});
    check("R9 count moved on", count, v + 16'h0101);
    check("R9 high capture untouched", {8'd0, cap_hi}, 16'h0);
    v = count; caph = 1'b1;
    @(negedge clk);
    caph = 1'b0;
    check("R9 high capture", {8'd0, cap_hi}, {8'd0, v[15:8]});

    // R9: 16-bit capture in chained mode
    do_reset();
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'd2);
    run_for(299, 1'b0);
    run = 1'b1; v = count; caph = 1'b1;
    @(negedge clk);
    run = 1'b0; caph = 1'b0;
    check("R9 wide capture", {cap_hi, cap_lo}, v);
    check("R5 wide count", count, 16'd300);

    // R8: pulse between ticks ignored, pulse across ticks accepted
    do_reset();
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'd3);
    @(negedge clk);
    tick = 1'b0; run = 1'b1; evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
    @(negedge clk);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 short pulse ignored", count, 16'h0);
    evt = 1'b1;
    repeat (2) @(negedge clk);
    evt = 1'b0;
    @(negedge clk);
    run = 1'b0;
    check("R8 long pulse counted", count, 16'h1);

    // R2: writing the mode restarts the prescaler
    do_reset();
    wr(3'd0, 8'd3); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'd0);
    run_for(2, 1'b0);
    wr(3'd3, 8'd0);
    run_for(2, 1'b0);
    @(negedge clk);
    check("R2 restart on mode write", count, 16'h0);
    run_for(2, 1'b0);
    @(negedge clk);
    check("R2 pulse after restart", count, 16'h0101);

    // R10: set wins over same-clock clear
    do_reset();
    wr(3'd1, 8'd0); wr(3'd2, 8'hFF); wr(3'd3, 8'd0);
    @(negedge clk);
    run = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
    @(negedge clk);
    run = 1'b0; wr_en = 1'b0;
    check("R10 set beats clear", {15'd0, flag_lo}, 16'h1);

    report();
  end

endmodule